// File: doc/BRIEF.md
# Binary-Weighted Pulse-Rate DAC Sequencer

This block sequences a pulse-counting digital-to-analog converter. It takes an N-bit code and uses each bit to gate a pulse generator. Every generator runs from one reference clock. The most significant bit's generator runs fastest, and each lower bit runs at half the rate of the bit above it. Over one sample period the merged pulses add up to a count M, and M is the value that a downstream summing chain turns into a voltage. Here the block reports M as a number, together with a one-cycle valid flag.

The sample period is 2^N reference cycles. With that length, bit k fires exactly 2^k times per period, so M equals the applied code. A free-running binary prescaler produces the rates and also marks each period boundary. A new code may be offered at any cycle. It is held in a shadow register and applied only when the next period begins. Code changes therefore always line up with the sample boundaries and never split a period.

Top module: `pulse_rate_dac`

## Requirements
- R1: While rst_ni is low, pulse_o, count_o and count_valid_o are all zero. The applied code after reset is zero, so the first reported count is 0.
- R2: count_valid_o pulses once every 2^WIDTH_P reference cycles. The first pulse comes 2^WIDTH_P rising edges after reset is released.
- R3: During one period, pulse_o[k] is high on exactly 2^k cycles if bit k of the applied code is 1, and on no cycle if it is 0.
- R4: The count_o value presented with count_valid_o equals the code that was applied during the period just ended.
- R5: A load (load_i high, with word_i) that arrives before the last cycle of a period leaves the current period's pulses and count unchanged. The new code takes effect at the start of the next period.
- R6: When several loads arrive within one period, the last one is the code applied in the next period.
- R7: A load in the last cycle of a period (prescaler all ones) applies to the very next period.
- R8: Without a new load, the applied code carries on unchanged from one period to the next.
- R9: count_valid_o is high for one cycle only, and count_o holds its value between valid pulses.
- R10: Each pulse on bit k lasts a single cycle. Consecutive pulses on bit k are exactly 2^(WIDTH_P-k) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | WIDTH_P | Code to apply at the next period boundary |
| load_i | input | 1 | Load strobe for word_i |
| pulse_o | output | WIDTH_P | Gated pulse stream per bit; bit k is weight 2^k |
| count_o | output | WIDTH_P | Total pulse count M of the last finished period |
| count_valid_o | output | 1 | One-cycle flag marking a new count_o |

## Verification
The bench goes after load timing: loads in the middle of a period, several loads in one period, and a load in the exact boundary cycle. A design that let a load through at once would report a count that mixes the old and new codes. A design that dropped the load in the boundary cycle would lag by a full period. Per-bit pulse totals and spacing are checked for sparse, dense, all-ones and all-zero codes. A wrong prescaler tap gives wrong per-bit totals or wrong gaps, even in cases where M by chance comes out right. The bench also checks the period length and that count_o holds between valid pulses, which catches an accumulator that is not cleared or a flag that stays high.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int unsigned DAC_WIDTH = 8;

  typedef enum logic [1:0] {
    LD_IDLE    = 2'd0,
    LD_PENDING = 2'd1
  } load_state_e;
endpackage

// File: rtl/dac_prescaler.sv
module dac_prescaler #(
  parameter int unsigned WIDTH_P = dac_pkg::DAC_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [WIDTH_P-1:0] tick_o,
  output logic               wrap_o
);
  logic [WIDTH_P-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  // stage s fires once every 2^(s+1) cycles
  for (genvar s = 0; s < WIDTH_P; s++) begin : g_stage
    assign tick_o[s] = &cnt_q[s:0];
  end

  assign wrap_o = tick_o[WIDTH_P-1];

  p_wrap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (tick_o == '0));
endmodule

// File: rtl/dac_word_latch.sv
module dac_word_latch #(
  parameter int unsigned WIDTH_P = dac_pkg::DAC_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wrap_i,
  input  logic               load_i,
  input  logic [WIDTH_P-1:0] word_i,
  output logic [WIDTH_P-1:0] active_o
);
  import dac_pkg::*;

  logic [WIDTH_P-1:0] shadow_q;
  load_state_e        st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_o <= '0;
      st_q     <= LD_IDLE;
    end else if (wrap_i) begin
      st_q <= LD_IDLE;
      if (load_i)                 active_o <= word_i;
      else if (st_q == LD_PENDING) active_o <= shadow_q;
    end else if (load_i) begin
      shadow_q <= word_i;
      st_q     <= LD_PENDING;
    end
  end

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(active_o));
  p_pend_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (st_q == LD_IDLE));
endmodule

// File: rtl/dac_pulse_gate.sv
module dac_pulse_gate #(
  parameter int unsigned WIDTH_P = dac_pkg::DAC_WIDTH
) (
  input  logic [WIDTH_P-1:0] active_i,
  input  logic [WIDTH_P-1:0] tick_i,
  output logic [WIDTH_P-1:0] pulse_o
);
  // MSB takes the fastest stage, LSB the slowest
  for (genvar k = 0; k < WIDTH_P; k++) begin : g_bit
    assign pulse_o[k] = active_i[k] & tick_i[WIDTH_P-1-k];
  end
endmodule

// File: rtl/dac_pulse_summer.sv
module dac_pulse_summer #(
  parameter int unsigned WIDTH_P = dac_pkg::DAC_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wrap_i,
  input  logic [WIDTH_P-1:0] pulse_i,
  output logic [WIDTH_P-1:0] count_o,
  output logic               valid_o
);
  logic [WIDTH_P-1:0] acc_q, sum;

  always_comb begin
    sum = acc_q;
    for (int i = 0; i < int'(WIDTH_P); i++)
      sum = sum + {{(WIDTH_P-1){1'b0}}, pulse_i[i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      count_o <= '0;
      valid_o <= 1'b0;
    end else if (wrap_i) begin
      acc_q   <= '0;
      count_o <= sum;
      valid_o <= 1'b1;
    end else begin
      acc_q   <= sum;
      valid_o <= 1'b0;
    end
  end

  p_valid_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_count_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(count_o));
endmodule

// File: rtl/pulse_rate_dac.sv
module pulse_rate_dac #(
  parameter int unsigned WIDTH_P = dac_pkg::DAC_WIDTH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [WIDTH_P-1:0] word_i,
  input  logic               load_i,
  output logic [WIDTH_P-1:0] pulse_o,
  output logic [WIDTH_P-1:0] count_o,
  output logic               count_valid_o
);
  logic [WIDTH_P-1:0] tick, active;
  logic               wrap;

  dac_prescaler #(.WIDTH_P(WIDTH_P)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick), .wrap_o(wrap));

  dac_word_latch #(.WIDTH_P(WIDTH_P)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .load_i(load_i),
    .word_i(word_i), .active_o(active));

  dac_pulse_gate #(.WIDTH_P(WIDTH_P)) u_gate (
    .active_i(active), .tick_i(tick), .pulse_o(pulse_o));

  dac_pulse_summer #(.WIDTH_P(WIDTH_P)) u_sum (
    .clk_i(clk_i), .rst_ni(rst_ni), .wrap_i(wrap), .pulse_i(pulse_o),
    .count_o(count_o), .valid_o(count_valid_o));

  p_count_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_valid_o |-> (count_o == $past(active)));
  p_msb_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o[WIDTH_P-1] |=> !pulse_o[WIDTH_P-1]);
endmodule

// File: tb/pulse_rate_dac_test.sv
module pulse_rate_dac_test;
  localparam int W = 8;
  localparam int PER = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] word = '0;
  logic         load = 1'b0;
  logic [W-1:0] pulse, cnt;
  logic         vld;

  int total = 0, bad = 0;
  int pc [W];
  int last_at [W];
  int gap_bad, hold_bad, cyc, m;

  pulse_rate_dac #(.WIDTH_P(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .load_i(load),
    .pulse_o(pulse), .count_o(cnt), .count_valid_o(vld));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Entered at a negedge where vld was just seen; ends at the next one.
  task automatic run_period(input int la, input logic [W-1:0] wa,
                            input int lb, input logic [W-1:0] wb);
    logic [W-1:0] c0 = cnt;
    cyc = 0; gap_bad = 0; hold_bad = 0;
    for (int k = 0; k < W; k++) begin pc[k] = 0; last_at[k] = -1; end
    forever begin
      for (int k = 0; k < W; k++)
        if (pulse[k]) begin
          pc[k]++;
          if (last_at[k] >= 0 && cyc - last_at[k] != (1 << (W - k))) gap_bad++;
          last_at[k] = cyc;
        end
      if (cnt != c0) hold_bad++;
      if (cyc == la)      begin load = 1'b1; word = wa; end
      else if (cyc == lb) begin load = 1'b1; word = wb; end
      else                load = 1'b0;
      @(negedge clk);
      cyc++;
      if (vld || cyc > 2 * PER) break;
    end
    load = 1'b0;
    m = int'(cnt);
  endtask

  task automatic check_period(input logic [W-1:0] exp_w, input string tag);
    check(m == int'(exp_w), {tag, " R4 count"}, m, int'(exp_w));
    check(cyc == PER, {tag, " R2 period"}, cyc, PER);
    check(hold_bad == 0, {tag, " R9 hold"}, hold_bad, 0);
    for (int k = 0; k < W; k++)
      check(pc[k] == (exp_w[k] ? (1 << k) : 0), {tag, " R3 bit count"}, pc[k],
            exp_w[k] ? (1 << k) : 0);
  endtask

  task automatic t_reset;
    #20;
    check(pulse == '0, "R1 pulse in reset", int'(pulse), 0);
    check(cnt == '0, "R1 count in reset", int'(cnt), 0);
    check(vld == 1'b0, "R1 valid in reset", int'(vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cyc = 0;
    while (!vld && cyc <= 2 * PER) begin @(negedge clk); cyc++; end
    check(cyc == PER, "R2 first valid", cyc, PER);
    check(cnt == '0, "R1 first count", int'(cnt), 0);
    @(negedge clk);
    check(vld == 1'b0, "R9 valid single", int'(vld), 0);
    while (!vld) @(negedge clk);
  endtask

  task automatic t_code(input logic [W-1:0] w);
    run_period(10, w, -1, '0);
    run_period(-1, '0, -1, '0);
    check_period(w, "code");
    check(gap_bad == 0, "R10 pulse gap", gap_bad, 0);
  endtask

  task automatic t_mid;
    run_period(-1, '0, -1, '0);
    run_period(100, 8'h3C, -1, '0);
    check(m == 8'h5A, "R5 mid load not applied", m, 8'h5A);
    run_period(-1, '0, -1, '0);
    check_period(8'h3C, "R5 next");
  endtask

  task automatic t_multi;
    run_period(5, 8'h11, 200, 8'hC3);
    check(m == 8'h3C, "R6 current kept", m, 8'h3C);
    run_period(-1, '0, -1, '0);
    check(m == 8'hC3, "R6 last load wins", m, 8'hC3);
  endtask

  task automatic t_boundary;
    run_period(PER - 1, 8'h69, -1, '0);
    check(m == 8'hC3, "R7 boundary current", m, 8'hC3);
    run_period(-1, '0, -1, '0);
    check_period(8'h69, "R7 boundary next");
  endtask

  task automatic t_persist;
    run_period(-1, '0, -1, '0);
    check(m == 8'h69, "R8 persist 1", m, 8'h69);
    run_period(-1, '0, -1, '0);
    check(m == 8'h69, "R8 persist 2", m, 8'h69);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_code(8'hFF);
    t_code(8'h80);
    t_code(8'h01);
    t_code(8'hA5);
    t_code(8'h00);
    t_code(8'h5A);
    t_mid();
    t_multi();
    t_boundary();
    t_persist();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule